// File: doc/BRIEF.md
# Sixteen-Entry Register File with Pair and Short-Register Modes

This block holds the sixteen general-purpose registers of a small load/store core. Registers 0 to 11 are 16 bits wide. Registers 12 and 13, the return-address register (index 14) and the stack pointer (index 15) can hold 32 bits. Two combinational read ports and one clocked write port each take a register index and a size code. The size code selects one of three accesses: the low byte of a register, its low 16-bit word, or a 32-bit value. A 32-bit value either comes from two adjacent 16-bit registers or is a native 32-bit register taken whole.

A mode bit, held inside the block, chooses how registers 12, 13 and 14 behave. When it is clear, they are native 32-bit registers. When it is set, only their low 16 bits are kept, and they pair with their neighbours like the narrow registers do. In that mode, register 14 on top of register 13 forms the 32-bit extended return address. The stack pointer stays a 32-bit register in both modes. The decoder drives the indices and sizes. The ALU and address generator consume the read data.

Top module: `gpr_file`

## Requirements
- R1: During and after reset (rst_ni low, active-low), every register reads as zero and the mode bit is 0 (native 32-bit mode).
- R2: A byte write (size code 0) replaces bits 7:0 of the named register and keeps every other bit. A byte read returns bits 7:0, zero-extended to 32 bits.
- R3: A word write (size code 1) replaces bits 15:0 of the named register. On a native 32-bit register, bits 31:16 are kept. A word read returns bits 15:0, zero-extended.
- R4: A pair access (size code 2) that starts at a 16-bit register n places the low half of the 32-bit value in register n and the high half in register n+1, both for reads and for writes.
- R5: With the mode bit 0, a pair access naming register 12, 13, 14 or 15 reads or writes that register as a single 32-bit value.
- R6: With the mode bit 1, registers 12, 13 and 14 hold 16 bits. Any write to them clears bits 31:16. Pair accesses starting at 11 or 12 combine them with the next register.
- R7: With the mode bit 1, a pair access naming register 13 or register 14 uses the extended return address: bits 15:0 in register 13 and bits 31:16 in register 14.
- R8: These accesses are illegal and raise the port's illegal flag: a pair access starting at register 11 with the mode bit 0, and any access with size code 3. An illegal read returns zero. An illegal write changes nothing.
- R9: Writes take effect at the rising clock edge. A read in the same cycle as a write to the same register returns the value from before that write.
- R10: The mode bit loads from mode_i on a cycle with mode_we_i high and holds otherwise. The new value governs accesses from the next cycle on, so a write in the same cycle uses the old mode. The stack pointer is a 32-bit register in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Load the short-register mode bit |
| mode_i | input | 1 | New mode value: 1 selects 16-bit registers 12 to 14 |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_size_i | input | 2 | Write size: 0 byte, 1 word, 2 pair, 3 reserved |
| wr_data_i | input | 32 | Write data |
| wr_illegal_o | output | 1 | Current write request is illegal |
| ra_idx_i | input | 4 | Read port A index |
| ra_size_i | input | 2 | Read port A size code |
| ra_data_o | output | 32 | Read port A data |
| ra_illegal_o | output | 1 | Read port A request is illegal |
| rb_idx_i | input | 4 | Read port B index |
| rb_size_i | input | 2 | Read port B size code |
| rb_data_o | output | 32 | Read port B data |
| rb_illegal_o | output | 1 | Read port B request is illegal |

## Verification
The bench builds the block with its default parameters: sixteen registers, 16-bit narrow width, the first wide register at index 12 and the return-address register at index 14. Half of the random indices fall on registers 10 to 15. This places the 11/12 boundary, the extended return-address pair and the stack pointer in most cycles, in both modes. Mode flips are rare and random, so values written in one mode are read back in the other. This exposes whether upper halves were cleared or kept.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_PAIR = 2'd2,
        SZ_RSVD = 2'd3
    } gpr_size_e;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_SINGLE = 2'd1,
        ACC_DIRECT = 2'd2,
        ACC_SPLIT  = 2'd3
    } gpr_acc_e;

endpackage

// File: rtl/gpr_pair_map.sv
// Resolves an (index, size, mode) request into the registers it touches.
module gpr_pair_map #(
    parameter int NREG       = 16,
    parameter int FIRST_WIDE = 12,
    parameter int RA_IDX     = 14,
    localparam int IDX_W     = $clog2(NREG)
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [1:0]        size_i,
    input  logic              short_i,
    output gpr_pkg::gpr_acc_e kind_o,
    output logic [IDX_W-1:0]  lo_o,
    output logic [IDX_W-1:0]  hi_o,
    output logic              illegal_o
);
    import gpr_pkg::*;

    localparam logic [IDX_W-1:0] FW_IDX = IDX_W'(FIRST_WIDE);
    localparam logic [IDX_W-1:0] RA_I   = IDX_W'(RA_IDX);
    localparam logic [IDX_W-1:0] RA_LO  = IDX_W'(RA_IDX - 1);

    function automatic logic is_wide(input logic [IDX_W-1:0] i, input logic sm);
        return (i >= FW_IDX) && !(sm && (i <= RA_I));
    endfunction

    logic [IDX_W-1:0] nxt_idx;
    assign nxt_idx = idx_i + IDX_W'(1);

    always_comb begin
        kind_o    = ACC_NONE;
        lo_o      = idx_i;
        hi_o      = idx_i;
        illegal_o = 1'b0;
        case (gpr_size_e'(size_i))
            SZ_BYTE, SZ_WORD: kind_o = ACC_SINGLE;
            SZ_PAIR: begin
                if (is_wide(idx_i, short_i)) begin
                    kind_o = ACC_DIRECT;
                end else if (short_i && (idx_i == RA_I)) begin
                    kind_o = ACC_SPLIT;
                    lo_o   = RA_LO;
                    hi_o   = RA_I;
                end else if (is_wide(nxt_idx, short_i)) begin
                    illegal_o = 1'b1;
                end else begin
                    kind_o = ACC_SPLIT;
                    hi_o   = nxt_idx;
                end
            end
            default: illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/gpr_read_port.sv
// One combinational read port: map the request, then select and assemble data.
module gpr_read_port #(
    parameter int NREG       = 16,
    parameter int NARROW_W   = 16,
    parameter int FIRST_WIDE = 12,
    parameter int RA_IDX     = 14,
    localparam int IDX_W     = $clog2(NREG),
    localparam int WIDE_W    = 2 * NARROW_W,
    localparam int BYTE_W    = NARROW_W / 2
) (
    input  logic [NREG-1:0][WIDE_W-1:0] regs_i,
    input  logic                        short_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [1:0]                  size_i,
    output logic [WIDE_W-1:0]           data_o,
    output logic                        illegal_o
);
    import gpr_pkg::*;

    gpr_acc_e         kind;
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;

    gpr_pair_map #(
        .NREG       (NREG),
        .FIRST_WIDE (FIRST_WIDE),
        .RA_IDX     (RA_IDX)
    ) u_map (
        .idx_i     (idx_i),
        .size_i    (size_i),
        .short_i   (short_i),
        .kind_o    (kind),
        .lo_o      (lo),
        .hi_o      (hi),
        .illegal_o (illegal_o)
    );

    logic [WIDE_W-1:0] lo_reg;
    logic [WIDE_W-1:0] hi_reg;
    assign lo_reg = regs_i[lo];
    assign hi_reg = regs_i[hi];

    always_comb begin
        data_o = '0;
        case (kind)
            ACC_SINGLE: begin
                if (gpr_size_e'(size_i) == SZ_BYTE)
                    data_o = WIDE_W'(lo_reg[BYTE_W-1:0]);
                else
                    data_o = WIDE_W'(lo_reg[NARROW_W-1:0]);
            end
            ACC_DIRECT: data_o = lo_reg;
            ACC_SPLIT:  data_o = {hi_reg[NARROW_W-1:0], lo_reg[NARROW_W-1:0]};
            default:    data_o = '0;
        endcase
    end

endmodule

// File: rtl/gpr_file.sv
// Register file top: storage, mode bit, write merge, two read ports.
module gpr_file #(
    parameter int NREG       = 16,
    parameter int NARROW_W   = 16,
    parameter int FIRST_WIDE = 12,
    parameter int RA_IDX     = 14,
    localparam int IDX_W     = $clog2(NREG),
    localparam int WIDE_W    = 2 * NARROW_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_we_i,
    input  logic              mode_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [1:0]        wr_size_i,
    input  logic [WIDE_W-1:0] wr_data_i,
    output logic              wr_illegal_o,
    input  logic [IDX_W-1:0]  ra_idx_i,
    input  logic [1:0]        ra_size_i,
    output logic [WIDE_W-1:0] ra_data_o,
    output logic              ra_illegal_o,
    input  logic [IDX_W-1:0]  rb_idx_i,
    input  logic [1:0]        rb_size_i,
    output logic [WIDE_W-1:0] rb_data_o,
    output logic              rb_illegal_o
);
    import gpr_pkg::*;

    localparam int BYTE_W = NARROW_W / 2;
    localparam int N_RD   = 2;

    typedef struct packed {
        logic                        short_mode;
        logic [NREG-1:0][WIDE_W-1:0] regs;
    } state_t;

    state_t state_d, state_q;

    logic [NREG-1:0][WIDE_W-1:0] regs_q;
    logic                        short_q;
    assign regs_q  = state_q.regs;
    assign short_q = state_q.short_mode;

    // ---------------- write request mapping ----------------
    gpr_acc_e         w_kind;
    logic [IDX_W-1:0] w_lo;
    logic [IDX_W-1:0] w_hi;
    logic             w_ill;

    gpr_pair_map #(
        .NREG       (NREG),
        .FIRST_WIDE (FIRST_WIDE),
        .RA_IDX     (RA_IDX)
    ) u_wmap (
        .idx_i     (wr_idx_i),
        .size_i    (wr_size_i),
        .short_i   (short_q),
        .kind_o    (w_kind),
        .lo_o      (w_lo),
        .hi_o      (w_hi),
        .illegal_o (w_ill)
    );

    assign wr_illegal_o = w_ill;

    // ---------------- next-state computation ----------------
    always_comb begin
        state_d = state_q;
        if (mode_we_i)
            state_d.short_mode = mode_i;
        if (wr_en_i && !w_ill) begin
            for (int i = 0; i < NREG; i++) begin
                logic touched;
                touched = 1'b0;
                if (w_lo == IDX_W'(i)) begin
                    case (w_kind)
                        ACC_SINGLE: begin
                            touched = 1'b1;
                            if (gpr_size_e'(wr_size_i) == SZ_BYTE)
                                state_d.regs[i][BYTE_W-1:0] = wr_data_i[BYTE_W-1:0];
                            else
                                state_d.regs[i][NARROW_W-1:0] = wr_data_i[NARROW_W-1:0];
                        end
                        ACC_DIRECT: begin
                            touched = 1'b1;
                            state_d.regs[i] = wr_data_i;
                        end
                        ACC_SPLIT: begin
                            touched = 1'b1;
                            state_d.regs[i][NARROW_W-1:0] = wr_data_i[NARROW_W-1:0];
                        end
                        default: touched = 1'b0;
                    endcase
                end
                if ((w_kind == ACC_SPLIT) && (w_hi == IDX_W'(i))) begin
                    touched = 1'b1;
                    state_d.regs[i][NARROW_W-1:0] = wr_data_i[WIDE_W-1:NARROW_W];
                end
                if (touched && short_q && (i >= FIRST_WIDE) && (i <= RA_IDX))
                    state_d.regs[i][WIDE_W-1:NARROW_W] = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    // ---------------- read ports ----------------
    logic [N_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [N_RD-1:0][1:0]        rd_size;
    logic [N_RD-1:0][WIDE_W-1:0] rd_data;
    logic [N_RD-1:0]             rd_ill;

    assign rd_idx  = {rb_idx_i, ra_idx_i};
    assign rd_size = {rb_size_i, ra_size_i};

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        gpr_read_port #(
            .NREG       (NREG),
            .NARROW_W   (NARROW_W),
            .FIRST_WIDE (FIRST_WIDE),
            .RA_IDX     (RA_IDX)
        ) u_port (
            .regs_i    (regs_q),
            .short_i   (short_q),
            .idx_i     (rd_idx[p]),
            .size_i    (rd_size[p]),
            .data_o    (rd_data[p]),
            .illegal_o (rd_ill[p])
        );
    end

    assign ra_data_o    = rd_data[0];
    assign ra_illegal_o = rd_ill[0];
    assign rb_data_o    = rd_data[1];
    assign rb_illegal_o = rd_ill[1];

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
    parameter int NREG       = 16,
    parameter int NARROW_W   = 16,
    parameter int FIRST_WIDE = 12,
    localparam int IDX_W     = $clog2(NREG),
    localparam int WIDE_W    = 2 * NARROW_W,
    localparam int BYTE_W    = NARROW_W / 2
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        mode_we_i,
    input logic                        wr_en_i,
    input logic [IDX_W-1:0]            wr_idx_i,
    input logic [1:0]                  wr_size_i,
    input logic                        wr_illegal_o,
    input logic [1:0]                  ra_size_i,
    input logic [WIDE_W-1:0]           ra_data_o,
    input logic                        ra_illegal_o,
    input logic [NREG-1:0][WIDE_W-1:0] regs_q,
    input logic                        short_q
);

    assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_we_i |=> $stable(short_q));

    assert_illegal_write_inert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_illegal_o && !mode_we_i) |=> $stable(regs_q));

    assert_illegal_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ra_illegal_o |-> (ra_data_o == '0));

    assert_byte_read_zext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ra_size_i == 2'd0) |-> (ra_data_o[WIDE_W-1:BYTE_W] == '0));

    assert_byte_write_keeps_upper_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_illegal_o && (wr_size_i == 2'd0) && !short_q)
        |=> (regs_q[$past(wr_idx_i)][WIDE_W-1:BYTE_W]
             == $past(regs_q[wr_idx_i][WIDE_W-1:BYTE_W])));

    assert_short_write_clears_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_illegal_o && short_q && (wr_idx_i == IDX_W'(FIRST_WIDE)))
        |=> (regs_q[FIRST_WIDE][WIDE_W-1:NARROW_W] == '0));

endmodule

bind gpr_file gpr_file_chk #(
    .NREG       (NREG),
    .NARROW_W   (NARROW_W),
    .FIRST_WIDE (FIRST_WIDE)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_we_i    (mode_we_i),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_size_i    (wr_size_i),
    .wr_illegal_o (wr_illegal_o),
    .ra_size_i    (ra_size_i),
    .ra_data_o    (ra_data_o),
    .ra_illegal_o (ra_illegal_o),
    .regs_q       (regs_q),
    .short_q      (short_q)
);

// File: tb/tb_gpr_file.sv
`timescale 1ns/1ps
module tb_gpr_file;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_we, mode_v, wr_en;
    logic [3:0]  wr_idx, ra_idx, rb_idx;
    logic [1:0]  wr_size, ra_size, rb_size;
    logic [31:0] wr_data, ra_data, rb_data;
    logic        wr_ill, ra_ill, rb_ill;

    always #2 clk = ~clk;

    gpr_file dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode_v),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_size_i(wr_size), .wr_data_i(wr_data),
        .wr_illegal_o(wr_ill),
        .ra_idx_i(ra_idx), .ra_size_i(ra_size), .ra_data_o(ra_data), .ra_illegal_o(ra_ill),
        .rb_idx_i(rb_idx), .rb_size_i(rb_size), .rb_data_o(rb_data), .rb_illegal_o(rb_ill)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m [16];
    logic        m_sm;

    function automatic logic m_wide(input int i);
        return (i >= 12) && !(m_sm && (i <= 14));
    endfunction

    function automatic logic [31:0] model_rd(input int idx, input int sz, output logic ill);
        ill = 1'b0;
        case (sz)
            0: return {24'h0, m[idx][7:0]};
            1: return {16'h0, m[idx][15:0]};
            2: begin
                if (m_wide(idx)) return m[idx];
                if (m_sm && idx == 14) return {m[14][15:0], m[13][15:0]};
                if (m_wide(idx + 1)) begin ill = 1'b1; return 32'h0; end
                return {m[idx+1][15:0], m[idx][15:0]};
            end
            default: begin ill = 1'b1; return 32'h0; end
        endcase
    endfunction

    task automatic model_wr(input int idx, input int sz, input logic [31:0] d);
        logic ill;
        logic [31:0] unused;
        bit touched [16];
        unused = model_rd(idx, sz, ill);
        if (ill) return;
        for (int j = 0; j < 16; j++) touched[j] = 0;
        case (sz)
            0: begin m[idx][7:0] = d[7:0]; touched[idx] = 1; end
            1: begin m[idx][15:0] = d[15:0]; touched[idx] = 1; end
            default: begin
                if (m_wide(idx)) begin
                    m[idx] = d; touched[idx] = 1;
                end else if (m_sm && idx == 14) begin
                    m[13][15:0] = d[15:0]; m[14][15:0] = d[31:16];
                    touched[13] = 1; touched[14] = 1;
                end else begin
                    m[idx][15:0] = d[15:0]; m[idx+1][15:0] = d[31:16];
                    touched[idx] = 1; touched[idx+1] = 1;
                end
            end
        endcase
        for (int j = 12; j <= 14; j++)
            if (m_sm && touched[j]) m[j][31:16] = 16'h0;
    endtask

    function automatic string tag_for(input int idx, input int sz);
        logic ill;
        logic [31:0] v;
        v = model_rd(idx, sz, ill);
        if (ill) return "R8";
        if (sz == 2 && m_sm && (idx == 13 || idx == 14)) return "R7";
        if (m_sm && idx >= 11 && idx <= 14) return "R6";
        if (sz == 2 && idx >= 12) return "R5";
        if (sz == 2) return "R4";
        if (sz == 0) return "R2";
        return "R3";
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Inputs are set after a falling edge; checks before the rising edge.
    task automatic do_cycle(input string force_tag);
        logic ia, ib, iw;
        logic [31:0] ea, eb, ew;
        string ta, tb;
        #1;
        ea = model_rd(int'(ra_idx), int'(ra_size), ia);
        eb = model_rd(int'(rb_idx), int'(rb_size), ib);
        ew = model_rd(int'(wr_idx), int'(wr_size), iw);
        ta = (force_tag != "") ? force_tag : tag_for(int'(ra_idx), int'(ra_size));
        tb = (force_tag != "") ? force_tag : tag_for(int'(rb_idx), int'(rb_size));
        chk(ta, "port A data", ra_data, ea);
        chk(ta, "port A illegal", {31'h0, ra_ill}, {31'h0, ia});
        chk(tb, "port B data", rb_data, eb);
        chk(tb, "port B illegal", {31'h0, rb_ill}, {31'h0, ib});
        if (wr_en) chk("R8", "write illegal", {31'h0, wr_ill}, {31'h0, iw});
        if (ew === 32'hx) $display("unreachable");
        @(posedge clk);
        if (wr_en) model_wr(int'(wr_idx), int'(wr_size), wr_data);
        if (mode_we) m_sm = mode_v;
        @(negedge clk);
    endtask

    task automatic idle();
        mode_we = 0; mode_v = 0; wr_en = 0; wr_idx = 0; wr_size = 0; wr_data = 0;
        ra_idx = 0; ra_size = 1; rb_idx = 0; rb_size = 1;
    endtask

    task automatic set_wr(input int idx, input int sz, input logic [31:0] d);
        wr_en = 1; wr_idx = 4'(idx); wr_size = 2'(sz); wr_data = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: got=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int j = 0; j < 16; j++) m[j] = 32'h0;
        m_sm = 0;
        idle();
        rst_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values visible during reset
        ra_idx = 4'd15; ra_size = 2'd2;
        #1 chk("R1", "SP during reset", ra_data, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R1: all registers zero, mode 0 (pair at 11 illegal only in mode 0)
        for (int i = 0; i < 16; i++) begin
            ra_idx = 4'(i); ra_size = 2'd1; rb_idx = 4'(i); rb_size = 2'd2;
            do_cycle("R1");
        end
        ra_idx = 4'd11; ra_size = 2'd2;
        #1 chk("R1", "mode bit default", {31'h0, ra_ill}, 32'h1);

        // R9: same-cycle read sees old value
        idle();
        set_wr(3, 1, 32'h0000_BEEF); ra_idx = 4'd3; ra_size = 2'd1;
        do_cycle("R9");
        idle(); ra_idx = 4'd3; ra_size = 2'd1;
        #1 chk("R9", "value after edge", ra_data, 32'h0000_BEEF);
        do_cycle("R9");

        // R8: pair write at 11 in mode 0 has no effect
        set_wr(11, 2, 32'h1234_5678); ra_idx = 4'd11; ra_size = 2'd2;
        do_cycle("R8");
        idle(); ra_idx = 4'd11; ra_size = 2'd1; rb_idx = 4'd12; rb_size = 2'd2;
        #1 chk("R8", "R11 untouched", ra_data, 32'h0);
        do_cycle("R8");

        // R10: mode change and write in the same cycle -> write uses old mode
        mode_we = 1; mode_v = 1; set_wr(12, 2, 32'hCAFE_F00D);
        do_cycle("R10");
        idle(); ra_idx = 4'd12; ra_size = 2'd2; rb_idx = 4'd15; rb_size = 2'd2;
        #1 chk("R10", "pair 12 in short mode", ra_data, 32'h0000_F00D);
        do_cycle("R10");

        // R7: extended return address pair
        set_wr(14, 2, 32'h1111_2222);
        do_cycle("R7");
        idle(); ra_idx = 4'd13; ra_size = 2'd2; rb_idx = 4'd14; rb_size = 2'd1;
        #1 chk("R7", "extended RA", ra_data, 32'h1111_2222);
        do_cycle("R7");

        // R6: short-mode write clears upper bits, visible after returning to mode 0
        mode_we = 1; mode_v = 0; do_cycle("R6");
        idle(); set_wr(13, 2, 32'hFFFF_AAAA); do_cycle("R5");
        idle(); mode_we = 1; mode_v = 1; do_cycle("R6");
        idle(); set_wr(13, 0, 32'h0000_0055); do_cycle("R6");
        idle(); mode_we = 1; mode_v = 0; do_cycle("R6");
        idle(); ra_idx = 4'd13; ra_size = 2'd2;
        #1 chk("R6", "upper cleared", ra_data, 32'h0000_AA55);
        do_cycle("R6");

        // R2/R3: byte and word writes keep upper bits of a native register
        set_wr(15, 2, 32'hA5A5_5A5A); do_cycle("R5");
        idle(); set_wr(15, 0, 32'h0000_00C3); do_cycle("R2");
        idle(); set_wr(15, 1, 32'h0000_7E7E); do_cycle("R3");
        idle(); ra_idx = 4'd15; ra_size = 2'd2;
        #1 chk("R3", "SP word merge", ra_data, 32'hA5A5_7E7E);
        do_cycle("R3");

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            mode_we = ($urandom % 50) == 0;
            mode_v  = 1'($urandom);
            wr_en   = ($urandom % 4) != 0;
            wr_idx  = ($urandom % 2) ? 4'(10 + $urandom % 6) : 4'($urandom);
            wr_size = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
            wr_data = $urandom;
            ra_idx  = ($urandom % 2) ? 4'(10 + $urandom % 6) : 4'($urandom);
            ra_size = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
            rb_idx  = ($urandom % 2) ? 4'(10 + $urandom % 6) : 4'($urandom);
            rb_size = 2'($urandom % 3);
            do_cycle("");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule